// File: doc/BRIEF.md
# Four-Pixel Region Hit Buffer

This block is the digital logic shared by a cluster of four neighbouring pixels. It watches each pixel's discriminator line, measures how long each pulse stays high (time over threshold, ToT) and parks every hit in a small local buffer. It does not stream hits out as they arrive. Each buffered hit carries its own latency countdown. When the countdown runs out, the hit is compared with the trigger line at that moment. A hit that matches is kept for readout. A hit that does not match is thrown away and its slot is reused.

Kept hits are offered through a request/grant pair. The region raises a request while at least one matched hit waits. It presents the oldest waiting hit, as a four-bit pixel pattern and four ToT fields, and frees that slot on the clock edge where the grant is seen. When more hits are in flight than the buffer can hold, the new hit is dropped and a sticky overflow flag records that something was lost.

Top module: `pxr_hit_buffer`

## Requirements
- R1: While reset is held and just after it is released, `rd_req_o` and `ovf_o` are 0.
- R2: A hit starts at a clock edge where `disc_i[p]` is sampled 1 after being 0 at the previous edge. All pixels that start at the same edge share one slot. Bit p of `rd_hitmap_o` is set for pixel p.
- R3: The ToT of pixel p is the number of clock edges at which its line was sampled high, counted from the start edge on and saturating at 15. It is stored when the line is next sampled low and appears in `rd_tot_o[4p+3:4p]`. Pixels outside the hit pattern read 0.
- R4: Take a hit that starts at edge k, with `latency_i` = L sampled at edge k. That hit is matched only if `trig_i` is sampled 1 at edge k+L+1. A trigger at any other edge does not keep it.
- R5: A slot whose countdown ends without a trigger is free again from the next cycle. It is never offered for reading.
- R6: There are 5 slots. A hit that starts while all 5 are occupied is dropped and never read. `ovf_o` goes to 1 at that edge and stays 1 until reset.
- R7: `rd_req_o` is 1 while any matched hit waits. Pattern and ToT stay unchanged until an edge where `rd_grant_i` is 1. That edge frees the slot, and the next waiting hit, if any, is presented from the following cycle.
- R8: Matched hits are presented in the order their countdowns ended, oldest first, one per granted edge.
- R9: `rd_grant_i` sampled while `rd_req_o` is 0 has no effect on buffered hits.
- R10: Each slot keeps the latency value sampled when its hit started. A later change of `latency_i` does not move its matching edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Region clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disc_i | input | 4 | Discriminator line of each pixel |
| trig_i | input | 1 | Trigger pulse, sampled at countdown ends |
| latency_i | input | 8 | Countdown length in cycles, taken at hit start |
| rd_grant_i | input | 1 | Readout grant; frees the presented slot |
| rd_req_o | output | 1 | A matched hit is waiting to be read |
| rd_hitmap_o | output | 4 | Pixel pattern of the presented hit |
| rd_tot_o | output | 16 | ToT of pixel p in bits 4p+3:4p |
| ovf_o | output | 1 | Sticky flag: a hit was lost for lack of a slot |

## Verification
Some properties are checked on every cycle: that overflow never clears by itself and only rises after a pixel start, that presented data holds still while a request waits for its grant, that a request never shows an empty pattern, and that no ToT field is non-zero outside the pattern. Other behaviour depends on what happened many cycles earlier, and only the bench scenarios can show it. This covers the exact matching edge for a given latency, the saturation of ToT, oldest-first ordering, reuse of slots freed by unmatched countdowns, dropping of the sixth concurrent hit, and holding the latency taken at hit start.

// File: rtl/pxr_pkg.sv
package pxr_pkg;

    parameter int NPIX  = 4;   // pixels per region
    parameter int NSLOT = 5;   // buffer slots
    parameter int TOT_W = 4;   // ToT counter width
    parameter int LAT_W = 8;   // latency countdown width

    localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;
    localparam int DATA_W = NPIX * TOT_W;

    typedef enum logic [1:0] {
        SL_FREE  = 2'd0,
        SL_WAIT  = 2'd1,
        SL_READY = 2'd2
    } slot_st_e;

    typedef struct packed {
        slot_st_e              st;
        logic [LAT_W-1:0]      lat;
        logic [NPIX-1:0]       hmap;
        logic [DATA_W-1:0]     tot;
    } slot_t;

endpackage

// File: rtl/pxr_tot_cnt.sv
// Per-pixel edge detection and saturating time-over-threshold counter.
module pxr_tot_cnt #(
    parameter int TOT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             disc_i,
    output logic             rise_o,
    output logic             fall_o,
    output logic [TOT_W-1:0] tot_o
);
    localparam logic [TOT_W-1:0] TOT_MAX = {TOT_W{1'b1}};

    typedef struct packed {
        logic             disc;
        logic [TOT_W-1:0] cnt;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.disc = disc_i;
        if (disc_i && !st_q.disc) begin
            st_d.cnt = {{(TOT_W-1){1'b0}}, 1'b1};
        end else if (disc_i && st_q.disc && (st_q.cnt != TOT_MAX)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_o = disc_i & ~st_q.disc;
    assign fall_o = ~disc_i & st_q.disc;
    // On the falling edge the register still holds the full count.
    assign tot_o  = st_q.cnt;

endmodule

// File: rtl/pxr_first_free.sv
// Lowest-index free slot picker.
module pxr_first_free #(
    parameter int N = 5,
    parameter int W = 3
) (
    input  logic [N-1:0] free_i,
    output logic         found_o,
    output logic [W-1:0] idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free_i[i]) begin
                found_o = 1'b1;
                idx_o   = W'(i);
            end
        end
    end
endmodule

// File: rtl/pxr_ready_queue.sv
// Order keeper for matched slots: indices enter when a countdown ends with
// a trigger and leave on a granted read, so the head is always the oldest.
module pxr_ready_queue #(
    parameter int N = 5,
    parameter int W = 3
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] push_i,
    input  logic         pop_i,
    output logic         valid_o,
    output logic [W-1:0] head_o
);
    localparam int CW = $clog2(N + 1);
    localparam logic [CW-1:0] CAP = CW'(N);

    typedef struct packed {
        logic [N-1:0][W-1:0] ent;
        logic [CW-1:0]       cnt;
    } q_t;

    q_t q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (pop_i && (q_q.cnt != '0)) begin
            for (int i = 0; i < N - 1; i++) begin
                q_d.ent[i] = q_q.ent[i+1];
            end
            q_d.ent[N-1] = '0;
            q_d.cnt      = q_q.cnt - 1'b1;
        end
        // Same-cycle arrivals enter in slot index order.
        for (int i = 0; i < N; i++) begin
            if (push_i[i] && (q_d.cnt < CAP)) begin
                for (int j = 0; j < N; j++) begin
                    if (CW'(j) == q_d.cnt) begin
                        q_d.ent[j] = W'(i);
                    end
                end
                q_d.cnt = q_d.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign valid_o = (q_q.cnt != '0);
    assign head_o  = q_q.ent[0];

endmodule

// File: rtl/pxr_hit_buffer.sv
// Four-pixel region: ToT measurement, slot allocation, per-slot latency
// countdown, trigger match and oldest-first readout.
module pxr_hit_buffer
    import pxr_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NPIX-1:0]   disc_i,
    input  logic              trig_i,
    input  logic [LAT_W-1:0]  latency_i,
    input  logic              rd_grant_i,
    output logic              rd_req_o,
    output logic [NPIX-1:0]   rd_hitmap_o,
    output logic [DATA_W-1:0] rd_tot_o,
    output logic              ovf_o
);

    typedef struct packed {
        slot_t [NSLOT-1:0]           slots;
        logic  [NPIX-1:0][SLOT_W-1:0] owner;  // slot holding each pixel's open hit
        logic  [NPIX-1:0]             live;   // pixel has an open hit with a slot
        logic                         ovf;
    } reg_t;

    reg_t st_d, st_q;

    // Per-pixel front end
    logic [NPIX-1:0]             rise;
    logic [NPIX-1:0]             fall;
    logic [NPIX-1:0][TOT_W-1:0]  tot_cur;

    for (genvar p = 0; p < NPIX; p++) begin : g_pix
        pxr_tot_cnt #(
            .TOT_W (TOT_W)
        ) u_cnt (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .disc_i (disc_i[p]),
            .rise_o (rise[p]),
            .fall_o (fall[p]),
            .tot_o  (tot_cur[p])
        );
    end

    // Free slot selection
    logic [NSLOT-1:0] free_mask;
    logic             free_found;
    logic [SLOT_W-1:0] free_idx;

    for (genvar s = 0; s < NSLOT; s++) begin : g_free
        assign free_mask[s] = (st_q.slots[s].st == SL_FREE);
    end

    pxr_first_free #(
        .N (NSLOT),
        .W (SLOT_W)
    ) u_pick (
        .free_i  (free_mask),
        .found_o (free_found),
        .idx_o   (free_idx)
    );

    // Readout order
    logic [NSLOT-1:0]  push_mask;
    logic              pop;
    logic              q_valid;
    logic [SLOT_W-1:0] q_head;

    pxr_ready_queue #(
        .N (NSLOT),
        .W (SLOT_W)
    ) u_order (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .push_i  (push_mask),
        .pop_i   (pop),
        .valid_o (q_valid),
        .head_o  (q_head)
    );

    always_comb begin
        st_d      = st_q;
        push_mask = '0;
        pop       = 1'b0;

        // Countdown and trigger match
        for (int s = 0; s < NSLOT; s++) begin
            if (st_q.slots[s].st == SL_WAIT) begin
                if (st_q.slots[s].lat == '0) begin
                    if (trig_i) begin
                        st_d.slots[s].st = SL_READY;
                        push_mask[s]     = 1'b1;
                    end else begin
                        st_d.slots[s].st = SL_FREE;
                    end
                end else begin
                    st_d.slots[s].lat = st_q.slots[s].lat - 1'b1;
                end
            end
        end

        // Granted read frees the presented slot
        if (rd_grant_i && q_valid) begin
            st_d.slots[q_head].st = SL_FREE;
            pop                   = 1'b1;
        end

        // End of pulse: store ToT into the slot taken at hit start
        for (int p = 0; p < NPIX; p++) begin
            if (fall[p] && st_q.live[p]) begin
                if ((st_q.slots[st_q.owner[p]].st != SL_FREE) &&
                    st_q.slots[st_q.owner[p]].hmap[p]) begin
                    st_d.slots[st_q.owner[p]].tot[p*TOT_W +: TOT_W] = tot_cur[p];
                end
                st_d.live[p] = 1'b0;
            end
        end

        // New hit: one slot for every pixel starting this cycle
        if (|rise) begin
            if (free_found) begin
                st_d.slots[free_idx].st   = SL_WAIT;
                st_d.slots[free_idx].lat  = latency_i;
                st_d.slots[free_idx].hmap = rise;
                st_d.slots[free_idx].tot  = '0;
                for (int p = 0; p < NPIX; p++) begin
                    if (rise[p]) begin
                        st_d.owner[p] = free_idx;
                        st_d.live[p]  = 1'b1;
                    end
                end
            end else begin
                st_d.ovf = 1'b1;
                for (int p = 0; p < NPIX; p++) begin
                    if (rise[p]) begin
                        st_d.live[p] = 1'b0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_req_o    = q_valid;
    assign rd_hitmap_o = q_valid ? st_q.slots[q_head].hmap : '0;
    assign rd_tot_o    = q_valid ? st_q.slots[q_head].tot  : '0;
    assign ovf_o       = st_q.ovf;

endmodule

// File: rtl/pxr_hit_buffer_chk.sv
module pxr_hit_buffer_chk
    import pxr_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic [NPIX-1:0]   disc_i,
    input logic              rd_grant_i,
    input logic              rd_req_o,
    input logic [NPIX-1:0]   rd_hitmap_o,
    input logic [DATA_W-1:0] rd_tot_o,
    input logic              ovf_o
);
    logic [NPIX-1:0] disc_prev;
    logic            start_seen;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            disc_prev <= '0;
        end else begin
            disc_prev <= disc_i;
        end
    end

    assign start_seen = |(disc_i & ~disc_prev);

    a_r6_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_o |=> ovf_o);

    a_r6_ovf_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ovf_o) |-> $past(start_seen));

    a_r7_hold_until_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_req_o && !rd_grant_i) |=> (rd_req_o && $stable(rd_hitmap_o) && $stable(rd_tot_o)));

    a_r2_pattern_present: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_req_o |-> (rd_hitmap_o != '0));

    for (genvar p = 0; p < NPIX; p++) begin : g_tot
        a_r3_tot_in_pattern: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (rd_req_o && !rd_hitmap_o[p]) |-> (rd_tot_o[p*TOT_W +: TOT_W] == '0));
    end

endmodule

bind pxr_hit_buffer pxr_hit_buffer_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .disc_i      (disc_i),
    .rd_grant_i  (rd_grant_i),
    .rd_req_o    (rd_req_o),
    .rd_hitmap_o (rd_hitmap_o),
    .rd_tot_o    (rd_tot_o),
    .ovf_o       (ovf_o)
);

// File: tb/pxr_hit_buffer_tb.sv
module pxr_hit_buffer_tb;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [3:0]  disc_i = '0;
    logic        trig_i = 1'b0;
    logic [7:0]  latency_i = 8'd24;
    logic        rd_grant_i = 1'b0;
    logic        rd_req_o;
    logic [3:0]  rd_hitmap_o;
    logic [15:0] rd_tot_o;
    logic        ovf_o;

    pxr_hit_buffer u_dut (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .disc_i      (disc_i),
        .trig_i      (trig_i),
        .latency_i   (latency_i),
        .rd_grant_i  (rd_grant_i),
        .rd_req_o    (rd_req_o),
        .rd_hitmap_o (rd_hitmap_o),
        .rd_tot_o    (rd_tot_o),
        .ovf_o       (ovf_o)
    );

    always #4 clk_i = ~clk_i;   // 125 MHz

    int cyc = 0;
    always @(posedge clk_i) cyc <= cyc + 1;

    int    checks = 0;
    int    errors = 0;
    int    reads  = 0;
    bit    grant_en = 1'b0;
    bit    grant_force = 1'b0;
    string cur_req = "R3";
    bit    trig_plan[int];
    logic [19:0] exp_q[$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk_i);
    endtask

    // Driver: start a hit on the pixels with non-zero length; when matched,
    // plan the trigger for the matching edge and push the expected result.
    task automatic hit(input int l0, input int l1, input int l2, input int l3, input bit match);
        int          lens[4];
        logic [3:0]  m;
        logic [15:0] t;
        int          e;
        lens = '{l0, l1, l2, l3};
        m = '0;
        t = '0;
        for (int p = 0; p < 4; p++) begin
            if (lens[p] > 0) begin
                m[p] = 1'b1;
                t[p*4 +: 4] = (lens[p] > 15) ? 4'd15 : 4'(lens[p]);
            end
        end
        e = cyc + 1;
        disc_i = disc_i | m;
        if (match) begin
            trig_plan[e + int'(latency_i) + 1] = 1'b1;
            exp_q.push_back({m, t});
        end
        for (int p = 0; p < 4; p++) begin
            automatic int pp = p;
            automatic int ll = lens[p];
            if (ll > 0) begin
                fork
                    begin
                        repeat (ll) @(negedge clk_i);
                        disc_i[pp] = 1'b0;
                    end
                join_none
            end
        end
    endtask

    // Trigger driver and scoreboard monitor
    always @(negedge clk_i) begin
        trig_i = trig_plan.exists(cyc + 1);
        if (rst_ni && rd_req_o && (grant_en || grant_force)) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, cur_req, {12'd0, rd_hitmap_o, rd_tot_o}, 32'd0);
            end else begin
                chk({rd_hitmap_o, rd_tot_o} == exp_q[0], cur_req,
                    {12'd0, rd_hitmap_o, rd_tot_o}, {12'd0, exp_q[0]});
                void'(exp_q.pop_front());
            end
            reads++;
            rd_grant_i = 1'b1;
        end else begin
            rd_grant_i = grant_force;
        end
    end

    initial begin
        repeat (100000) @(posedge clk_i);
        errors++;
        $display("FAIL watchdog: run did not complete");
        summary();
    end

    initial begin
        int e;
        int r0;
        // R1: reset state
        step(3);
        chk(rd_req_o == 1'b0, "R1", 32'(rd_req_o), 0);
        chk(ovf_o == 1'b0, "R1", 32'(ovf_o), 0);
        rst_ni = 1'b1;
        step(2);
        chk(rd_req_o == 1'b0 && ovf_o == 1'b0, "R1", {rd_req_o, ovf_o}, 0);

        // R3 / R2: ToT values and shared slots
        grant_en = 1'b1;
        cur_req = "R3";
        hit(3, 0, 0, 0, 1'b1);
        step(40);
        cur_req = "R2";
        hit(2, 0, 7, 0, 1'b1);
        step(40);
        hit(1, 2, 3, 4, 1'b1);
        step(40);
        cur_req = "R3";
        hit(0, 0, 0, 20, 1'b1);   // saturates at 15
        step(50);
        chk(exp_q.size() == 0 && reads == 4, "R3", reads, 4);

        // R4: triggers one edge early and one edge late do not match
        cur_req = "R4";
        r0 = reads;
        e = cyc + 1;
        hit(5, 0, 0, 0, 1'b0);
        trig_plan[e + 24] = 1'b1;
        step(10);
        e = cyc + 1;
        hit(0, 4, 0, 0, 1'b0);
        trig_plan[e + 26] = 1'b1;
        step(40);
        chk(reads == r0 && rd_req_o == 1'b0, "R4", reads, r0);

        // R7 / R8: hold while not granted, then oldest first
        grant_en = 1'b0;
        cur_req = "R8";
        hit(1, 0, 0, 0, 1'b1);
        step(2);
        hit(0, 2, 0, 0, 1'b1);
        step(2);
        hit(0, 0, 3, 5, 1'b1);
        step(30);
        chk(rd_req_o == 1'b1, "R7", 32'(rd_req_o), 1);
        chk({rd_hitmap_o, rd_tot_o} == exp_q[0], "R7", {rd_hitmap_o, rd_tot_o}, exp_q[0]);
        step(6);
        chk({rd_hitmap_o, rd_tot_o} == exp_q[0], "R7", {rd_hitmap_o, rd_tot_o}, exp_q[0]);
        grant_en = 1'b1;
        step(10);
        chk(exp_q.size() == 0 && rd_req_o == 1'b0, "R8", 32'(exp_q.size()), 0);

        // R9: grant held high while nothing is ready
        cur_req = "R9";
        grant_force = 1'b1;
        r0 = reads;
        hit(0, 0, 2, 0, 1'b1);
        step(40);
        chk(reads == r0 + 1 && exp_q.size() == 0, "R9", reads, r0 + 1);
        grant_force = 1'b0;
        step(2);

        // R10: latency captured at hit start
        cur_req = "R10";
        hit(4, 0, 0, 0, 1'b1);
        step(1);
        latency_i = 8'd3;
        step(40);
        chk(exp_q.size() == 0, "R10", 32'(exp_q.size()), 0);
        latency_i = 8'd24;
        step(2);

        // R5: expired unmatched slots are reused
        cur_req = "R5";
        for (int i = 0; i < 5; i++) begin
            hit(1, 0, 0, 0, 1'b0);
            step(2);
        end
        step(30);
        for (int i = 0; i < 4; i++) begin
            hit(0, 1, 0, 0, 1'b0);
            step(2);
        end
        hit(0, 0, 0, 2, 1'b1);
        step(40);
        chk(ovf_o == 1'b0, "R5", 32'(ovf_o), 0);
        chk(exp_q.size() == 0, "R5", 32'(exp_q.size()), 0);

        // R6: sixth concurrent hit is dropped
        cur_req = "R6";
        for (int i = 0; i < 5; i++) begin
            hit(1, 0, 0, 0, 1'b0);
            step(2);
        end
        chk(ovf_o == 1'b0, "R6", 32'(ovf_o), 0);
        r0 = reads;
        e = cyc + 1;
        hit(0, 3, 0, 0, 1'b0);
        trig_plan[e + 25] = 1'b1;
        step(1);
        chk(ovf_o == 1'b1, "R6", 32'(ovf_o), 1);
        step(45);
        chk(reads == r0 && rd_req_o == 1'b0, "R6", reads, r0);
        hit(0, 0, 1, 0, 1'b1);
        step(40);
        chk(ovf_o == 1'b1 && exp_q.size() == 0, "R6", {ovf_o, 31'(exp_q.size())}, 32'h8000_0000);

        // R1: reset clears the sticky flag
        rst_ni = 1'b0;
        step(2);
        chk(ovf_o == 1'b0 && rd_req_o == 1'b0, "R1", {ovf_o, rd_req_o}, 0);
        rst_ni = 1'b1;
        step(2);
        summary();
    end

endmodule